// File: doc/BRIEF.md
# Ratio Clock-Enable Divider

This block derives several slower clock rates from one fast source clock. Each rate is a one-cycle clock-enable strobe in the source domain, so logic downstream stays on the source clock and acts only on strobe cycles. There are five rate domains: CPU, system bus, peripheral bus, memory and display. Each has its own 4-bit ratio code, and the codes select from an irregular set of divisors that mixes powers of two with multiples of three.

A separate integer divider produces the strobe for the USB rate. Its input is either every source cycle or every second source cycle, chosen by a source-select bit. It then divides that input by N+1. Software picks N so that the selected input is an integer multiple of 48 MHz. An output-enable bit gates the strobe of one chosen domain, display by default, onto the externally visible clock-enable.

All settings arrive through one write port that carries every field at once. A new divisor never cuts a period short. Each counter keeps its current period to the end and only then switches to the new setting.

Top module: `ratio_clk_div`

## Requirements
- R1: Ratio codes 0,1,2,3,4,5,6,7,8,9 give a strobe period of 1,2,3,4,6,8,12,16,24,32 source cycles respectively.
- R2: Ratio codes 10 through 15 give a strobe period of 1 source cycle.
- R3: The five domains are independent. Domain i takes its code from cfgRatio[4i+3:4i], with 0=CPU, 1=system bus, 2=peripheral bus, 3=memory and 4=display, and the strobe of domain i appears on domStrobe[i].
- R4: A new ratio code takes effect only after the current period of that domain ends. The first gap after a mid-period write equals the old divisor, and the gaps after it equal the new divisor.
- R5: Every strobe is high for one source cycle per period. All strobes are high in the first cycle after reset is released.
- R6: With cfgUsbSel=1 (full-rate input), usbStrobe has a period of cfgUsbDiv+1 source cycles.
- R7: With cfgUsbSel=0 (half-rate input), usbStrobe has a period of 2*(cfgUsbDiv+1) source cycles. A new divider value or source select applies only after the current USB period ends.
- R8: With cfgClkOe=1, extStrobe equals domStrobe[EXT_DOM] (display by default). With cfgClkOe=0, extStrobe stays low.
- R9: Fields are stored only on cycles where cfgWe=1. After reset all ratio codes are 0, cfgUsbSel is 0, the USB divider is 0 and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for all configuration fields |
| cfgRatio | input | NUM_DOM*4 | Packed ratio codes, domain i in bits [4i+3:4i] |
| cfgUsbSel | input | 1 | USB divider input: 1 = full rate, 0 = half rate |
| cfgUsbDiv | input | USB_DIV_W | USB divider value N (divide by N+1) |
| cfgClkOe | input | 1 | External clock-enable output gate |
| domStrobe | output | NUM_DOM | Per-domain clock-enable strobes |
| usbStrobe | output | 1 | USB-rate clock-enable strobe |
| extStrobe | output | 1 | Gated external strobe of domain EXT_DOM |

## Verification
A wrong counter or divisor register shows up as a strobe gap of the wrong length, and the first wrong gap appears within one period of the fault, at most 32 source cycles for a domain. A divisor loaded too early shows up as a gap right after a write that is shorter than the old divisor. That gap is measured in the very period that follows the write. A wrong phase in the half-rate USB input shows up as two strobes in consecutive cycles or as a gap that is not twice N+1, and this is visible from the first USB period after the change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 6;
  localparam int CNT_W  = DIV_W - 1;

  typedef struct packed {
    logic usbSel;
    logic clkOe;
  } cfgFlags_t;

  function automatic logic [DIV_W-1:0] ratioDiv(input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd1:    d = 6'd2;
      4'd2:    d = 6'd3;
      4'd3:    d = 6'd4;
      4'd4:    d = 6'd6;
      4'd5:    d = 6'd8;
      4'd6:    d = 6'd12;
      4'd7:    d = 6'd16;
      4'd8:    d = 6'd24;
      4'd9:    d = 6'd32;
      default: d = 6'd1;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ratio_cfg_ctrl.sv
module ratio_cfg_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_DOM   = 5,
  parameter int USB_DIV_W = 4,
  localparam int RAT_W    = NUM_DOM * CODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [RAT_W-1:0]     cfgRatio,
  input  logic                 cfgUsbSel,
  input  logic [USB_DIV_W-1:0] cfgUsbDiv,
  input  logic                 cfgClkOe,
  output logic [RAT_W-1:0]     ratioQ,
  output logic [USB_DIV_W-1:0] usbDivQ,
  output cfgFlags_t            flagsQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioQ <= '0;
      usbDivQ <= '0;
      flagsQ <= '0;
    end else if (cfgWe) begin
      ratioQ <= cfgRatio;
      usbDivQ <= cfgUsbDiv;
      flagsQ.usbSel <= cfgUsbSel;
      flagsQ.clkOe <= cfgClkOe;
    end
  end

  // R9: no write strobe, no change of stored fields
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> ($stable(ratioQ) && $stable(usbDivQ) && $stable(flagsQ)));
endmodule

// File: rtl/ratio_dom_counter.sv
module ratio_dom_counter
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] code,
  output logic              strobe
);
  logic [DIV_W-1:0] actDiv;
  logic [CNT_W-1:0] cnt;
  logic             lastCycle;

  assign lastCycle = ({1'b0, cnt} == (actDiv - 6'd1));
  assign strobe = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actDiv <= 6'd1;
      cnt <= '0;
    end else if (lastCycle) begin
      actDiv <= ratioDiv(code);
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: counter never leaves the current period
  a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, cnt} < actDiv));

  // R4: divisor only changes where a new period begins
  a_r4_switch_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actDiv) |-> (cnt == '0));

  // R1, R2: active divisor always one of the legal set
  a_r1_legal_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (actDiv inside {6'd1, 6'd2, 6'd3, 6'd4, 6'd6, 6'd8, 6'd12, 6'd16, 6'd24, 6'd32}));
endmodule

// File: rtl/usb_rate_div.sv
module usb_rate_div #(
  parameter int USB_DIV_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 selFull,
  input  logic [USB_DIV_W-1:0] divN,
  output logic                 strobe
);
  logic                 actSel;
  logic [USB_DIV_W-1:0] actN;
  logic [USB_DIV_W-1:0] usbCnt;
  logic                 halfPh;
  logic                 inEn;
  logic                 wrapNow;

  assign inEn = actSel | !halfPh;
  assign wrapNow = inEn && (usbCnt == actN);
  assign strobe = inEn && (usbCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel <= 1'b0;
      actN <= '0;
      usbCnt <= '0;
      halfPh <= 1'b0;
    end else begin
      halfPh <= inEn;
      if (wrapNow) begin
        usbCnt <= '0;
        actN <= divN;
        actSel <= selFull;
      end else if (inEn) begin
        usbCnt <= usbCnt + 1'b1;
      end
    end
  end

  // R6, R7: count stays within the divider range
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (usbCnt <= actN));

  // R7: half-rate input never enabled on two cycles in a row
  a_r7_half_gap: assert property (@(posedge clk) disable iff (!rstN)
    (inEn && !actSel && !wrapNow) |=> !inEn);
endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
  import clkdiv_pkg::*;
#(
  parameter int NUM_DOM   = 5,
  parameter int USB_DIV_W = 4,
  parameter int EXT_DOM   = 4,
  localparam int RAT_W    = NUM_DOM * CODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [RAT_W-1:0]     cfgRatio,
  input  logic                 cfgUsbSel,
  input  logic [USB_DIV_W-1:0] cfgUsbDiv,
  input  logic                 cfgClkOe,
  output logic [NUM_DOM-1:0]   domStrobe,
  output logic                 usbStrobe,
  output logic                 extStrobe
);
  logic [RAT_W-1:0]     ratioQ;
  logic [USB_DIV_W-1:0] usbDivQ;
  cfgFlags_t            flagsQ;

  ratio_cfg_ctrl #(.NUM_DOM(NUM_DOM), .USB_DIV_W(USB_DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRatio(cfgRatio),
    .cfgUsbSel(cfgUsbSel), .cfgUsbDiv(cfgUsbDiv), .cfgClkOe(cfgClkOe),
    .ratioQ(ratioQ), .usbDivQ(usbDivQ), .flagsQ(flagsQ)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : gDom
    ratio_dom_counter uCnt (
      .clk(clk), .rstN(rstN),
      .code(ratioQ[d*CODE_W +: CODE_W]),
      .strobe(domStrobe[d])
    );
  end

  usb_rate_div #(.USB_DIV_W(USB_DIV_W)) uUsb (
    .clk(clk), .rstN(rstN), .selFull(flagsQ.usbSel),
    .divN(usbDivQ), .strobe(usbStrobe)
  );

  assign extStrobe = domStrobe[EXT_DOM] & flagsQ.clkOe;
endmodule

// File: tb/tb_ratio_clk_div.sv
module tb_ratio_clk_div;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DOM = 5;
  localparam int USB_DIV_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [NUM_DOM*4-1:0] cfgRatio = '0;
  logic cfgUsbSel = 1'b0;
  logic [USB_DIV_W-1:0] cfgUsbDiv = '0;
  logic cfgClkOe = 1'b0;
  logic [NUM_DOM-1:0] domStrobe;
  logic usbStrobe;
  logic extStrobe;

  int checks = 0;
  int errors = 0;

  ratio_clk_div dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRatio(cfgRatio),
    .cfgUsbSel(cfgUsbSel), .cfgUsbDiv(cfgUsbDiv), .cfgClkOe(cfgClkOe),
    .domStrobe(domStrobe), .usbStrobe(usbStrobe), .extStrobe(extStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expDiv(input int code);
    case (code)
      1: return 2;  2: return 3;  3: return 4;  4: return 6;
      5: return 8;  6: return 12; 7: return 16; 8: return 24;
      9: return 32; default: return 1;
    endcase
  endfunction

  function automatic logic probe(input int sel);
    if (sel < NUM_DOM) return domStrobe[sel];
    if (sel == NUM_DOM) return usbStrobe;
    return extStrobe;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyCfg();
    @(negedge clk);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic gapFromHere(input int sel, output int gap);
    gap = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      gap++;
      if (probe(sel)) return;
    end
    gap = 0;
  endtask

  task automatic waitStrobe(input int sel);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (probe(sel)) return;
    end
  endtask

  task automatic measure(input int sel, output int gap);
    int g;
    waitStrobe(sel);
    gapFromHere(sel, g);
    waitStrobe(sel);
    gapFromHere(sel, gap);
  endtask

  task automatic testReset();
    int g;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(domStrobe == 5'b11111, "R5 all domain strobes in first cycle", domStrobe, 31);
    check(usbStrobe == 1'b1, "R5 usb strobe in first cycle", usbStrobe, 1);
    check(extStrobe == 1'b0, "R9 ext gated off after reset", extStrobe, 0);
    @(negedge clk);
    check(usbStrobe == 1'b0, "R9 half-rate default gap", usbStrobe, 0);
    check(domStrobe == 5'b11111, "R9 default code 0 divide by 1", domStrobe, 31);
    measure(NUM_DOM, g);
    check(g == 2, "R9 default usb period", g, 2);
  endtask

  task automatic testAllCodes();
    int g;
    for (int c = 0; c < 10; c++) begin
      cfgRatio[11:8] = c[3:0];
      applyCfg();
      measure(2, g);
      check(g == expDiv(c), $sformatf("R1 code %0d", c), g, expDiv(c));
    end
  endtask

  task automatic testReserved();
    int g;
    for (int c = 10; c < 16; c++) begin
      cfgRatio[7:4] = 4'd9;
      applyCfg();
      measure(1, g);
      cfgRatio[7:4] = c[3:0];
      applyCfg();
      measure(1, g);
      check(g == 1, $sformatf("R2 reserved code %0d", c), g, 1);
    end
  endtask

  task automatic testIndependent();
    int g;
    int codes[NUM_DOM] = '{1, 2, 4, 6, 9};
    for (int d = 0; d < NUM_DOM; d++) cfgRatio[d*4 +: 4] = codes[d][3:0];
    applyCfg();
    for (int d = 0; d < NUM_DOM; d++) begin
      measure(d, g);
      check(g == expDiv(codes[d]), $sformatf("R3 domain %0d", d), g, expDiv(codes[d]));
    end
  endtask

  task automatic testBoundary();
    int g;
    int n;
    cfgRatio[3:0] = 4'd9;
    applyCfg();
    measure(0, g);
    check(g == 32, "R4 settle div 32", g, 32);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 5) begin cfgRatio[3:0] = 4'd1; cfgWe = 1'b1; end
      if (n == 6) cfgWe = 1'b0;
      if (domStrobe[0]) break;
    end
    check(n == 32, "R4 old period completes", n, 32);
    gapFromHere(0, g);
    check(g == 2, "R4 new period after boundary", g, 2);
    gapFromHere(0, g);
    check(g == 2, "R5 repeat new period", g, 2);
  endtask

  task automatic testUsb();
    int g;
    int n;
    cfgUsbSel = 1'b1; cfgUsbDiv = 4'd2;
    applyCfg();
    measure(NUM_DOM, g);
    check(g == 3, "R6 full rate N=2", g, 3);
    cfgUsbSel = 1'b1; cfgUsbDiv = 4'd0;
    applyCfg();
    measure(NUM_DOM, g);
    check(g == 1, "R6 full rate N=0", g, 1);
    cfgUsbSel = 1'b0; cfgUsbDiv = 4'd2;
    applyCfg();
    measure(NUM_DOM, g);
    check(g == 6, "R7 half rate N=2", g, 6);
    cfgUsbSel = 1'b0; cfgUsbDiv = 4'd15;
    applyCfg();
    measure(NUM_DOM, g);
    check(g == 32, "R7 half rate N=15", g, 32);
    cfgUsbSel = 1'b1; cfgUsbDiv = 4'd7;
    applyCfg();
    measure(NUM_DOM, g);
    check(g == 8, "R6 full rate N=7", g, 8);
    waitStrobe(NUM_DOM);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) begin cfgUsbDiv = 4'd1; cfgWe = 1'b1; end
      if (n == 3) cfgWe = 1'b0;
      if (usbStrobe) break;
    end
    check(n == 8, "R7 usb old period completes", n, 8);
    gapFromHere(NUM_DOM, g);
    check(g == 2, "R7 usb new period", g, 2);
  endtask

  task automatic testExt();
    int g;
    int mism;
    int highs;
    cfgRatio[19:16] = 4'd3; cfgClkOe = 1'b1;
    applyCfg();
    measure(NUM_DOM + 1, g);
    check(g == 4, "R8 ext period with enable", g, 4);
    mism = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (extStrobe != domStrobe[4]) mism++;
    end
    check(mism == 0, "R8 ext follows display", mism, 0);
    cfgClkOe = 1'b0;
    applyCfg();
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (extStrobe) highs++;
    end
    check(highs == 0, "R8 ext low when disabled", highs, 0);
  endtask

  task automatic testNoWrite();
    int g;
    measure(4, g);
    check(g == 4, "R9 display before ignored data", g, 4);
    @(negedge clk);
    cfgRatio[19:16] = 4'd9; cfgUsbDiv = 4'd9; cfgUsbSel = 1'b0;
    repeat (40) @(negedge clk);
    measure(4, g);
    check(g == 4, "R9 display unchanged without write", g, 4);
    measure(NUM_DOM, g);
    check(g == 2, "R9 usb unchanged without write", g, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testAllCodes();
    testReserved();
    testIndependent();
    testBoundary();
    testUsb();
    testExt();
    testNoWrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule